// File: doc/BRIEF.md
# APB Cross-Domain Register Synchronizer

This block sits between an APB slave port, clocked by the bus clock, and a peripheral core running on an unrelated core clock. Software writes a control word (enable and soft-reset bits) and a secondary control word on the bus side. Each of these writes is carried into the core domain by its own toggle request/acknowledge handshake, and each handshake has a busy flag in a read-only status word. A write to a control word while any control transfer is still pending is refused with an APB error and has no effect.

In the other direction, the core domain keeps a saturating receive-error counter. Every change of it is shipped back to the bus domain, where it can be read. A sleep-exit pulse on the bus side raises a status flag and asks the core for a fresh copy of the counter. The flag drops when that fresh copy has landed.

Top module: `xdom_regsync`

## Requirements
- R1: After reset, every readable word (control, secondary control, status, error count) reads zero, and `core_enable_o`, `core_aux_o` and `core_swrst_o` are low.
- R2: `pready` is always high. A read of any offset other than 0x00, 0x04, 0x1C and 0x20 returns zero without an error. Status bits 31..4 always read zero.
- R3: A write to the control word at offset 0x00 with bit 0 clear stores bit 1 as the enable and sets status bit 1. Status bit 1 clears only after the handshake has returned. From then on `core_enable_o` equals the written bit, and control-word bit 1 reads it back.
- R4: A write to offset 0x00 with bit 0 set is a soft reset. It sets status bit 0 and gives one `core_swrst_o` pulse in the core clock. When status bit 0 clears, the control word (including bit 0) and the secondary control word read zero, and `core_enable_o` and `core_aux_o` are zero. The error count then reads zero.
- R5: A write to the secondary control word at offset 0x04 while the enable reads 1 sets status bit 2. When status bit 2 clears, `core_aux_o` equals the written value.
- R6: A write to offset 0x04 while the enable reads 0 leaves status bit 2 clear. `core_aux_o` follows the written value within a few core clocks.
- R7: A write to offset 0x00 or 0x04 while any of status bits 2..0 is set asserts `pslverr` in its access phase, and the addressed word keeps its value.
- R8: Each core-clock cycle with `core_err_i` high adds one to a core-side counter of CNT_W bits, which holds at 2^CNT_W-1. The latest value is copied to the bus side without request and read at offset 0x20.
- R9: A `wake_i` pulse sets status bit 3. Status bit 3 clears once a counter value taken after the pulse has reached offset 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error for refused writes |
| wake_i | input | 1 | Sleep-exit pulse, bus clock |
| cclk | input | 1 | Core clock |
| crst_n | input | 1 | Core-domain reset, active low |
| core_err_i | input | 1 | Receive error event, core clock |
| core_enable_o | output | 1 | Enable as seen by the core |
| core_aux_o | output | AUX_W | Secondary control as seen by the core |
| core_swrst_o | output | 1 | One-cycle soft reset pulse, core clock |

## Verification
The bench builds the block with CNT_W of 4, AUX_W of 8 and two synchronizer stages. The 4-bit counter brings saturation within about twenty error pulses. The bus clock runs at 8 ns and the core clock at 47 ns, so a refused second write falls well inside a pending handshake. A behavioural model of the enable, the secondary word and the error count is compared against the bus reads and the core-side outputs.

// File: rtl/xdom_regsync_pkg.sv
`timescale 1ns/1ps
package xdom_regsync_pkg;
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_AUX    = 8'h04;
  localparam logic [7:0] OFS_STATUS = 8'h1C;
  localparam logic [7:0] OFS_ERRCNT = 8'h20;

  typedef enum logic [1:0] {
    ST_SRST = 2'd0,
    ST_EN   = 2'd1,
    ST_AUX  = 2'd2,
    ST_WAKE = 2'd3
  } status_bit_e;
endpackage

// File: rtl/xs_sync.sv
`timescale 1ns/1ps
module xs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xs_tgl_src.sv
`timescale 1ns/1ps
module xs_tgl_src #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic ack_i,
  output logic req_o,
  output logic busy_o,
  output logic done_o
);
  logic req_q, req_d;
  logic ack_s;
  logic busy_q;

  xs_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ack_i), .q_o(ack_s)
  );

  assign busy_o = req_q ^ ack_s;
  assign done_o = busy_q & ~busy_o;
  assign req_o  = req_q;

  always_comb begin
    req_d = req_q ^ (launch_i & ~busy_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      busy_q <= busy_o;
    end
  end

  AST_NO_LAUNCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> !busy_o); // R7
endmodule

// File: rtl/xs_tgl_dst.sv
`timescale 1ns/1ps
module xs_tgl_dst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic strobe_o,
  output logic ack_o
);
  logic req_s;
  logic lvl_q;

  xs_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d_i(req_i), .q_o(req_s)
  );

  assign strobe_o = req_s ^ lvl_q;
  assign ack_o    = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= req_s;
  end
endmodule

// File: rtl/xdom_regsync.sv
`timescale 1ns/1ps
module xdom_regsync
  import xdom_regsync_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int AUX_W       = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              wake_i,
  input  logic              cclk,
  input  logic              crst_n,
  input  logic              core_err_i,
  output logic              core_enable_o,
  output logic [AUX_W-1:0]  core_aux_o,
  output logic              core_swrst_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int HOLD_W = CNT_W + 1;

  // ---------------- bus domain ----------------
  logic acc_wr, acc_rd;
  logic sel_ctrl, sel_aux, sel_stat, sel_cnt;
  logic [3:0] status;
  logic ctl_blocked;
  logic wr_ctrl_ok, aux_ok;
  logic srst_launch, en_launch, aux_launch, rf_launch;

  logic             en_q, en_d;
  logic [AUX_W-1:0] aux_q, aux_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wk_q, wk_d;
  logic             rfp_q, rfp_d;

  logic srst_req, srst_busy, srst_done;
  logic en_req, en_busy, en_done;
  logic aux_req, aux_busy, aux_done;
  logic rf_req, rf_busy, rf_done;
  logic cb_strobe, cb_ack;

  // ---------------- core domain ----------------
  logic srst_strobe, srst_ack;
  logic en_strobe, en_ack;
  logic aux_strobe, aux_ack;
  logic rf_strobe, rf_lvl;
  logic cb_req, cb_busy, cb_done, cb_launch;

  logic              en_c_q, en_c_d;
  logic [AUX_W-1:0]  aux_c_q, aux_c_d;
  logic [CNT_W-1:0]  cnt_c_q, cnt_c_d;
  logic              pend_q, pend_d;
  logic [HOLD_W-1:0] hold_q, hold_d;

  // ---------- bus decode ----------
  assign acc_wr   = psel & penable & pwrite;
  assign acc_rd   = psel & penable & ~pwrite;
  assign sel_ctrl = (paddr == ADDR_W'(OFS_CTRL));
  assign sel_aux  = (paddr == ADDR_W'(OFS_AUX));
  assign sel_stat = (paddr == ADDR_W'(OFS_STATUS));
  assign sel_cnt  = (paddr == ADDR_W'(OFS_ERRCNT));

  always_comb begin
    status          = '0;
    status[ST_SRST] = srst_busy;
    status[ST_EN]   = en_busy;
    status[ST_AUX]  = aux_busy;
    status[ST_WAKE] = wk_q;
  end

  assign ctl_blocked = srst_busy | en_busy | aux_busy;
  assign wr_ctrl_ok  = acc_wr & sel_ctrl & ~ctl_blocked;
  assign aux_ok      = acc_wr & sel_aux  & ~ctl_blocked;
  assign srst_launch = wr_ctrl_ok & pwdata[0];
  assign en_launch   = wr_ctrl_ok & ~pwdata[0];
  assign aux_launch  = aux_ok & en_q;
  assign rf_launch   = (wake_i | rfp_q) & ~rf_busy;

  assign pready  = 1'b1;
  assign pslverr = acc_wr & (sel_ctrl | sel_aux) & ctl_blocked;

  always_comb begin
    prdata = '0;
    if (acc_rd) begin
      if (sel_ctrl)      prdata = {30'd0, en_q, 1'b0};
      else if (sel_aux)  prdata = {{(32-AUX_W){1'b0}}, aux_q};
      else if (sel_stat) prdata = {28'd0, status};
      else if (sel_cnt)  prdata = {{(32-CNT_W){1'b0}}, cnt_q};
    end
  end

  // ---------- bus next state ----------
  always_comb begin
    en_d  = en_q;
    aux_d = aux_q;
    cnt_d = cnt_q;
    wk_d  = wk_q;
    rfp_d = rfp_q;
    if (srst_launch) begin
      en_d  = 1'b0;
      aux_d = '0;
    end else begin
      if (en_launch) en_d  = pwdata[1];
      if (aux_ok)    aux_d = pwdata[AUX_W-1:0];
    end
    if (srst_done)      cnt_d = '0;
    else if (cb_strobe) cnt_d = hold_q[CNT_W-1:0];
    if (wake_i)
      wk_d = 1'b1;
    else if (cb_strobe && !rfp_q && (hold_q[CNT_W] == rf_req))
      wk_d = 1'b0;
    rfp_d = (wake_i | rfp_q) & rf_busy;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      en_q  <= 1'b0;
      aux_q <= '0;
      cnt_q <= '0;
      wk_q  <= 1'b0;
      rfp_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      aux_q <= aux_d;
      cnt_q <= cnt_d;
      wk_q  <= wk_d;
      rfp_q <= rfp_d;
    end
  end

  // ---------- handshakes bus -> core ----------
  xs_tgl_src #(.STAGES(SYNC_STAGES)) u_srst_src (
    .clk(pclk), .rst_n(presetn), .launch_i(srst_launch), .ack_i(srst_ack),
    .req_o(srst_req), .busy_o(srst_busy), .done_o(srst_done));
  xs_tgl_dst #(.STAGES(SYNC_STAGES)) u_srst_dst (
    .clk(cclk), .rst_n(crst_n), .req_i(srst_req),
    .strobe_o(srst_strobe), .ack_o(srst_ack));

  xs_tgl_src #(.STAGES(SYNC_STAGES)) u_en_src (
    .clk(pclk), .rst_n(presetn), .launch_i(en_launch), .ack_i(en_ack),
    .req_o(en_req), .busy_o(en_busy), .done_o(en_done));
  xs_tgl_dst #(.STAGES(SYNC_STAGES)) u_en_dst (
    .clk(cclk), .rst_n(crst_n), .req_i(en_req),
    .strobe_o(en_strobe), .ack_o(en_ack));

  xs_tgl_src #(.STAGES(SYNC_STAGES)) u_aux_src (
    .clk(pclk), .rst_n(presetn), .launch_i(aux_launch), .ack_i(aux_ack),
    .req_o(aux_req), .busy_o(aux_busy), .done_o(aux_done));
  xs_tgl_dst #(.STAGES(SYNC_STAGES)) u_aux_dst (
    .clk(cclk), .rst_n(crst_n), .req_i(aux_req),
    .strobe_o(aux_strobe), .ack_o(aux_ack));

  xs_tgl_src #(.STAGES(SYNC_STAGES)) u_rf_src (
    .clk(pclk), .rst_n(presetn), .launch_i(rf_launch), .ack_i(rf_lvl),
    .req_o(rf_req), .busy_o(rf_busy), .done_o(rf_done));
  xs_tgl_dst #(.STAGES(SYNC_STAGES)) u_rf_dst (
    .clk(cclk), .rst_n(crst_n), .req_i(rf_req),
    .strobe_o(rf_strobe), .ack_o(rf_lvl));

  // ---------- handshake core -> bus ----------
  assign cb_launch = pend_q & ~cb_busy;

  xs_tgl_src #(.STAGES(SYNC_STAGES)) u_cb_src (
    .clk(cclk), .rst_n(crst_n), .launch_i(cb_launch), .ack_i(cb_ack),
    .req_o(cb_req), .busy_o(cb_busy), .done_o(cb_done));
  xs_tgl_dst #(.STAGES(SYNC_STAGES)) u_cb_dst (
    .clk(pclk), .rst_n(presetn), .req_i(cb_req),
    .strobe_o(cb_strobe), .ack_o(cb_ack));

  // ---------- core next state ----------
  always_comb begin
    en_c_d  = en_c_q;
    aux_c_d = aux_c_q;
    cnt_c_d = cnt_c_q;
    pend_d  = pend_q & ~cb_launch;
    hold_d  = hold_q;
    if (cb_launch) hold_d = {rf_lvl, cnt_c_q};
    if (srst_strobe) begin
      en_c_d  = 1'b0;
      aux_c_d = '0;
      cnt_c_d = '0;
      pend_d  = 1'b1;
    end else begin
      if (en_strobe) en_c_d = en_q;
      if (aux_strobe || !en_c_q) aux_c_d = aux_q;
      if (core_err_i && (cnt_c_q != CNT_MAX)) begin
        cnt_c_d = cnt_c_q + 1'b1;
        pend_d  = 1'b1;
      end
    end
    if (rf_strobe) pend_d = 1'b1;
  end

  always_ff @(posedge cclk or negedge crst_n) begin
    if (!crst_n) begin
      en_c_q  <= 1'b0;
      aux_c_q <= '0;
      cnt_c_q <= '0;
      pend_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      en_c_q  <= en_c_d;
      aux_c_q <= aux_c_d;
      cnt_c_q <= cnt_c_d;
      pend_q  <= pend_d;
      hold_q  <= hold_d;
    end
  end

  assign core_enable_o = en_c_q;
  assign core_aux_o    = aux_c_q;
  assign core_swrst_o  = srst_strobe;

  // ---------- assertions ----------
  AST_REFUSED_AUX_KEEPS: assert property (@(posedge pclk) disable iff (!presetn)
    (acc_wr && sel_aux && pslverr) |=> $stable(aux_q)); // R7
  AST_SRST_LEAVES_CLEAR: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(srst_busy) |-> (!en_q && aux_q == '0)); // R4
  AST_AUX_BUSY_NEEDS_EN: assert property (@(posedge pclk) disable iff (!presetn)
    aux_busy |-> en_q); // R5
  AST_WAKE_SETS_FLAG: assert property (@(posedge pclk) disable iff (!presetn)
    wake_i |=> wk_q); // R9
  AST_CNT_HOLDS_AT_MAX: assert property (@(posedge cclk) disable iff (!crst_n)
    (core_err_i && cnt_c_q == CNT_MAX && !srst_strobe) |=> (cnt_c_q == CNT_MAX)); // R8
endmodule

// File: tb/test_xdom_regsync.sv
`timescale 1ns/1ps
module test_xdom_regsync;
  localparam int AUX_W = 8;
  localparam int CNT_W = 4;

  logic pclk, presetn, psel, penable, pwrite, wake_i;
  logic [7:0] paddr;
  logic [31:0] pwdata, prdata;
  logic pready, pslverr;
  logic cclk, crst_n, core_err_i, core_enable_o, core_swrst_o;
  logic [AUX_W-1:0] core_aux_o;

  int total = 0;
  int bad = 0;
  int swrst_seen = 0;
  bit finished = 0;
  int exp_cnt = 0;
  int exp_en = 0;
  int exp_aux = 0;

  xdom_regsync #(.ADDR_W(8), .AUX_W(AUX_W), .CNT_W(CNT_W), .SYNC_STAGES(2)) i_xdom_regsync (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .wake_i(wake_i), .cclk(cclk), .crst_n(crst_n), .core_err_i(core_err_i),
    .core_enable_o(core_enable_o), .core_aux_o(core_aux_o), .core_swrst_o(core_swrst_o));

  initial pclk = 0;
  always #4 pclk = ~pclk;
  initial cclk = 0;
  always #23.5 cclk = ~cclk;

  always @(posedge cclk) if (crst_n && core_swrst_o) swrst_seen++;

  // pready stays high on every bus clock (R2)
  always @(negedge pclk) if (presetn && !finished) begin
    total++;
    if (pready !== 1'b1) begin
      bad++;
      $display("FAIL R2 pready act=%0b exp=1", pready);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d, output logic err);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1; #1 err = pslverr;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d, output logic err);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata; err = pslverr;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic wait_status(input logic [31:0] mask, input string req);
    logic [31:0] d;
    logic e;
    int n = 0;
    apb_rd(8'h1C, d, e);
    while (((d & mask) != 0) && n < 300) begin
      apb_rd(8'h1C, d, e);
      n++;
    end
    check(req, d & mask, 32'h0);
  endtask

  task automatic err_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge cclk); core_err_i = 1;
      @(negedge cclk); core_err_i = 0;
      if (exp_cnt < (1 << CNT_W) - 1) exp_cnt++;
    end
    repeat (20) @(negedge cclk);
  endtask

  initial begin
    logic [31:0] d;
    logic e;
    presetn = 0; crst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    wake_i = 0; core_err_i = 0;
    repeat (5) @(negedge cclk);
    presetn = 1; crst_n = 1;
    repeat (3) @(negedge pclk);

    // R1 reset state
    apb_rd(8'h00, d, e); check("R1 ctrl", d, 0);
    apb_rd(8'h04, d, e); check("R1 aux", d, 0);
    apb_rd(8'h1C, d, e); check("R1 status", d, 0);
    apb_rd(8'h20, d, e); check("R1 errcnt", d, 0);
    check("R1 core outputs", {core_enable_o, core_swrst_o, core_aux_o}, 0);

    // R2 unmapped offset
    apb_rd(8'h10, d, e); check("R2 unmapped data", d, 0); check("R2 unmapped err", e, 0);

    // R6 aux write while disabled
    exp_aux = 'h5A;
    apb_wr(8'h04, 32'h5A, e); check("R6 no error", e, 0);
    apb_rd(8'h1C, d, e); check("R6 status bit2 clear", d[2], 0);
    repeat (6) @(negedge cclk);
    check("R6 core_aux follows", core_aux_o, exp_aux);

    // R3 enable
    exp_en = 1;
    apb_wr(8'h00, 32'h2, e); check("R3 no error", e, 0);
    apb_rd(8'h1C, d, e); check("R3 status busy", d, 32'h2);
    wait_status(32'h7, "R3 busy clears");
    check("R3 core_enable", core_enable_o, exp_en);
    apb_rd(8'h00, d, e); check("R3 ctrl readback", d, 32'h2);

    // R5 aux while enabled, R7 refused writes while busy
    apb_wr(8'h04, 32'hC3, e); check("R5 no error", e, 0);
    exp_aux = 'hC3;
    apb_wr(8'h04, 32'h11, e); check("R7 aux write refused", e, 1);
    apb_wr(8'h00, 32'h0, e); check("R7 ctrl write refused", e, 1);
    check("R5 core_aux unchanged while pending", core_aux_o, 'h5A);
    wait_status(32'h7, "R5 busy clears");
    check("R5 core_aux updated", core_aux_o, exp_aux);
    apb_rd(8'h04, d, e); check("R7 aux kept", d, exp_aux);
    apb_rd(8'h00, d, e); check("R7 ctrl kept", d, 32'h2);
    check("R7 core_enable kept", core_enable_o, exp_en);

    // R8 error counter
    err_pulses(5);
    apb_rd(8'h20, d, e); check("R8 count 5", d, exp_cnt);
    err_pulses(20);
    apb_rd(8'h20, d, e); check("R8 saturated", d, exp_cnt);
    check("R8 saturation value", exp_cnt, 15);

    // R9 wake
    @(negedge pclk); wake_i = 1;
    @(negedge pclk); wake_i = 0;
    apb_rd(8'h1C, d, e); check("R9 wake flag set", d, 32'h8);
    wait_status(32'h8, "R9 wake flag clears");
    apb_rd(8'h20, d, e); check("R9 fresh count", d, exp_cnt);

    // R4 soft reset
    apb_wr(8'h00, 32'h3, e); check("R4 no error", e, 0);
    apb_rd(8'h1C, d, e); check("R4 status bit0", d[0], 1);
    wait_status(32'h7, "R4 busy clears");
    exp_en = 0; exp_aux = 0; exp_cnt = 0;
    check("R4 one swrst pulse", swrst_seen, 1);
    apb_rd(8'h00, d, e); check("R4 ctrl zero", d, 0);
    apb_rd(8'h04, d, e); check("R4 aux zero", d, 0);
    apb_rd(8'h20, d, e); check("R4 errcnt zero", d, exp_cnt);
    check("R4 core_enable", core_enable_o, exp_en);
    check("R4 core_aux", core_aux_o, exp_aux);
    apb_rd(8'h1C, d, e); check("R2 status upper bits", d[31:4], 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule